// File: doc/BRIEF.md
# Two-Pass 64-bit Shifter

This execution-unit shifter performs logical left, logical right and arithmetic right shifts on a 64-bit operand. The only shifting hardware in it is a half-width (32-bit) funnel barrel. A narrow (32-bit) shift uses that barrel once and returns a sign-extended result in the cycle after the request is accepted. A wide (64-bit) shift uses the barrel twice. The first pass makes the low half of the result. The second pass makes the high half from operand words held in registers. During the second pass the block raises `stall`.

The surrounding pipeline drives a request with `in_valid` and holds further work back while `stall` is high. Any strobe presented during a stall cycle is dropped. A result is shown on `out_data` together with a single-cycle `out_valid` pulse, and `out_data` keeps its value until the next completion.

Top module: `shifter64_2pass`

## Requirements
- R1: `in_kind` encodes the operation. Bit 0 set means a right shift and bit 0 clear means a left shift. Bit 1 set on a right shift means arithmetic. Code 2'b00 is left logical, 2'b01 is right logical, 2'b11 is right arithmetic, and 2'b10 behaves as left logical.
- R2: In narrow mode (`in_wide`=0) the result is `in_data[31:0]` shifted by `in_amt[4:0]`, sign-extended from bit 31 to 64 bits. `in_data[63:32]` and `in_amt[5]` have no effect.
- R3: A wide request accepted at a clock edge makes `stall` high for exactly the following cycle.
- R4: A narrow request accepted at a clock edge gives `out_valid`=1 with its result in the following cycle, and `stall` stays low.
- R5: In wide mode the result is the full 64-bit `in_data` shifted by `in_amt[5:0]`. It appears with `out_valid`=1 in the cycle right after the stall cycle.
- R6: An arithmetic right shift fills the vacated bits with bit 63 of the operand in wide mode and with bit 31 in narrow mode.
- R7: A shift amount of zero returns the operand unchanged in wide mode, and the sign-extended low word in narrow mode.
- R8: A strobe presented while `stall` is high is ignored. It produces no result, and the pending wide result is unaffected.
- R9: While reset is active and after reset, `out_valid`, `stall` and `out_data` are zero.
- R10: `out_valid` is low in every cycle that does not follow an accepted narrow request or a stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 64 | Operand |
| in_amt | input | 6 | Shift amount |
| in_kind | input | 2 | Shift operation code (R1) |
| in_wide | input | 1 | 1 = 64-bit shift, 0 = 32-bit shift |
| out_data | output | 64 | Result, held until the next completion |
| out_valid | output | 1 | One-cycle result strobe |
| stall | output | 1 | High during the second pass of a wide shift |

## Verification
A corrupted second-pass register (the held operand words, the amount, the kind or the low half) shows up only in the wide result. It appears one cycle after the stall, as a wrong high word, or as a wrong low word when the low-half register is the one corrupted. A fault in the pass state appears at once as a missing or doubled stall pulse. It also appears one cycle later as a missing, extra or early `out_valid`. A wrong funnel input selection shows up at the boundary amounts 31, 32 and 63 and in arithmetic fills, on the very next result.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned HALF_W = 32;

  typedef enum logic [1:0] {
    SHK_LL  = 2'b00,
    SHK_RL  = 2'b01,
    SHK_LL2 = 2'b10,
    SHK_RA  = 2'b11
  } shk_e;

  function automatic logic kind_is_right(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_is_arith(input logic [1:0] k);
    return k[0] & k[1];
  endfunction
endpackage

// File: rtl/shf_funnel.sv
// Half-width funnel barrel: takes the word pair {up,dn} and returns HW bits.
// right: ({up,dn} >> k)[HW-1:0]    left: ({up,dn} << k)[2HW-1:HW]
module shf_funnel #(
  parameter int unsigned HW = 32,
  localparam int unsigned KW = $clog2(HW)
) (
  input  logic [HW-1:0] up,
  input  logic [HW-1:0] dn,
  input  logic [KW-1:0] k,
  input  logic          left,
  output logic [HW-1:0] res
);
  localparam int unsigned PW = 2 * HW;

  logic [PW-1:0] stage [0:KW];
  logic [PW-1:0] pair_fwd;
  logic [PW-1:0] pair_rev;
  logic [HW-1:0] low_rev;

  assign pair_fwd = {up, dn};

  always_comb begin
    for (int i = 0; i < PW; i++) pair_rev[i] = pair_fwd[PW-1-i];
  end

  // a left shift is a right shift of the bit-reversed pair
  assign stage[0] = left ? pair_rev : pair_fwd;

  for (genvar g = 0; g < KW; g++) begin : g_stage
    assign stage[g+1] = k[g] ? (stage[g] >> (1 << g)) : stage[g];
  end

  always_comb begin
    for (int i = 0; i < HW; i++) low_rev[i] = stage[KW][HW-1-i];
  end

  assign res = left ? low_rev : stage[KW][HW-1:0];
endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_wide,
  output logic accept,
  output logic take_wide,
  output logic pass2,
  output logic done_next
);
  logic pass2_q, pass2_d;

  assign accept    = in_valid & ~pass2_q;
  assign take_wide = accept & in_wide;
  assign pass2     = pass2_q;
  assign done_next = (accept & ~in_wide) | pass2_q;

  always_comb begin
    pass2_d = take_wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass2_q <= 1'b0;
    else        pass2_q <= pass2_d;
  end
endmodule

// File: rtl/shifter64_2pass.sv
module shifter64_2pass #(
  parameter int unsigned HW = shf_pkg::HALF_W,
  localparam int unsigned DW = 2 * HW,
  localparam int unsigned AW = $clog2(DW),
  localparam int unsigned KW = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] in_amt,
  input  logic [1:0]    in_kind,
  input  logic          in_wide,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          stall
);
  import shf_pkg::*;

  logic accept, take_wide, pass2, done_next;

  // second-pass holding registers
  logic [HW-1:0] hi_q, lo_q, low_res_q;
  logic [AW-1:0] amt_q;
  logic [1:0]    kind_q;
  logic [DW-1:0] out_q, out_d;
  logic          ov_q;

  // funnel operands
  logic [HW-1:0] f_up, f_dn, f_res;
  logic [KW-1:0] f_k;
  logic          f_left;

  logic [HW-1:0] in_hi, in_lo, in_fill, q_fill;
  logic          in_big, q_big;

  shf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .accept    (accept),
    .take_wide (take_wide),
    .pass2     (pass2),
    .done_next (done_next)
  );

  assign in_hi  = in_data[DW-1:HW];
  assign in_lo  = in_data[HW-1:0];
  assign in_big = in_amt[AW-1];
  assign q_big  = amt_q[AW-1];

  // fill word: sign of the selected width for arithmetic, else zero
  assign in_fill = kind_is_arith(in_kind)
                 ? {HW{in_wide ? in_hi[HW-1] : in_lo[HW-1]}} : '0;
  assign q_fill  = kind_is_arith(kind_q) ? {HW{hi_q[HW-1]}} : '0;

  always_comb begin
    f_up   = '0;
    f_dn   = '0;
    f_k    = in_amt[KW-1:0];
    f_left = ~kind_is_right(in_kind);
    if (pass2) begin
      // high half of a wide result
      f_k    = amt_q[KW-1:0];
      f_left = ~kind_is_right(kind_q);
      if (kind_is_right(kind_q)) begin
        f_up = q_fill;
        f_dn = q_big ? q_fill : hi_q;
      end else begin
        f_up = q_big ? lo_q : hi_q;
        f_dn = q_big ? '0   : lo_q;
      end
    end else if (in_wide) begin
      // low half of a wide result
      if (kind_is_right(in_kind)) begin
        f_up = in_big ? in_fill : in_hi;
        f_dn = in_big ? in_hi   : in_lo;
      end else begin
        f_up = in_big ? '0 : in_lo;
        f_dn = '0;
      end
    end else begin
      // narrow shift of the low word
      if (kind_is_right(in_kind)) begin
        f_up = in_fill;
        f_dn = in_lo;
      end else begin
        f_up = in_lo;
        f_dn = '0;
      end
    end
  end

  shf_funnel #(.HW(HW)) u_funnel (
    .up   (f_up),
    .dn   (f_dn),
    .k    (f_k),
    .left (f_left),
    .res  (f_res)
  );

  always_comb begin
    out_d = out_q;
    if (pass2)       out_d = {f_res, low_res_q};
    else if (accept) out_d = {{HW{f_res[HW-1]}}, f_res};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      low_res_q <= '0;
      amt_q     <= '0;
      kind_q    <= '0;
    end else if (take_wide) begin
      hi_q      <= in_hi;
      lo_q      <= in_lo;
      low_res_q <= f_res;
      amt_q     <= in_amt;
      kind_q    <= in_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= done_next;
      if (done_next) out_q <= out_d;
    end
  end

  assign out_data  = out_q;
  assign out_valid = ov_q;
  assign stall     = pass2;
endmodule

// File: rtl/shifter64_2pass_chk.sv
module shifter64_2pass_chk #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_wide,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          stall
);
  localparam int unsigned HW = DW / 2;

  a_r3_stall_after_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && in_wide) |=> stall);

  a_r3_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  a_r4_narrow_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && !in_wide) |=> (out_valid && !stall));

  a_r2_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && !in_wide) |=> (out_data[DW-1:HW] == {HW{out_data[HW-1]}}));

  a_r5_wide_done: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> out_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !in_valid) |=> !out_valid);

  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || $stable(out_data)));

  a_r9_reset: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !stall));
endmodule

bind shifter64_2pass shifter64_2pass_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_wide   (in_wide),
  .out_data  (out_data),
  .out_valid (out_valid),
  .stall     (stall)
);

// File: tb/shifter64_2pass_tb.sv
module shifter64_2pass_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic [5:0]  in_amt;
  logic [1:0]  in_kind;
  logic        in_wide;
  logic [63:0] out_data;
  logic        out_valid;
  logic        stall;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shifter64_2pass u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_amt(in_amt), .in_kind(in_kind), .in_wide(in_wide),
    .out_data(out_data), .out_valid(out_valid), .stall(stall)
  );

  function automatic logic [63:0] ref_shift(input logic [63:0] d, input logic [5:0] a,
                                            input logic [1:0] k, input logic w);
    logic [63:0] r;
    logic [31:0] n;
    if (w) begin
      if (!k[0])     r = d << a;
      else if (k[1]) r = $signed(d) >>> a;
      else           r = d >> a;
    end else begin
      if (!k[0])     n = d[31:0] << a[4:0];
      else if (k[1]) n = $signed(d[31:0]) >>> a[4:0];
      else           n = d[31:0] >> a[4:0];
      r = {{32{n[31]}}, n};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request; optionally hold a junk strobe during the stall cycle
  task automatic run_op(input logic [63:0] d, input logic [5:0] a, input logic [1:0] k,
                        input logic w, input bit junk, input string req);
    logic [63:0] exp;
    exp = ref_shift(d, a, k, w);
    in_valid = 1; in_data = d; in_amt = a; in_kind = k; in_wide = w;
    @(negedge clk);
    if (!w) begin
      in_valid = 0;
      check({req, " R4 valid/stall"}, {62'd0, out_valid, stall}, 64'd2);
      check({req, " result"}, out_data, exp);
    end else begin
      check("R3 stall in pass two", {62'd0, out_valid, stall}, 64'd1);
      if (junk) begin
        in_data = ~d; in_amt = a + 6'd7; in_kind = ~k; in_wide = $urandom_range(0, 1);
      end else in_valid = 0;
      @(negedge clk);
      in_valid = 0;
      check({req, " R5 valid after stall"}, {62'd0, out_valid, stall}, 64'd2);
      check({req, " result"}, out_data, exp);
      if (junk) begin
        @(negedge clk);
        check("R8 ignored strobe gives no result", {62'd0, out_valid, stall}, 64'd0);
        check("R8 result held", out_data, exp);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pat [4];
    void'($urandom(32'h5eed_1234));
    rst_n = 0; in_valid = 0; in_data = '0; in_amt = '0; in_kind = '0; in_wide = 0;
    #(CLK_PERIOD * 3 + 1);
    check("R9 reset outputs", {out_data[61:0], out_valid, stall}, 64'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R9 after reset", {out_data[61:0], out_valid, stall}, 64'd0);
    check("R10 idle no valid", {63'd0, out_valid}, 64'd0);

    pat[0] = 64'h8123_4567_89ab_cdef;
    pat[1] = 64'h7fff_0000_ffff_0001;
    pat[2] = 64'hffff_ffff_ffff_ffff;
    pat[3] = 64'h0000_0001_8000_0000;
    foreach (pat[p]) begin
      for (int k = 0; k < 4; k++) begin
        run_op(pat[p], 6'd0,  k[1:0], 1'b1, 0, "R7 wide amt0");
        run_op(pat[p], 6'd0,  k[1:0], 1'b0, 0, "R7 narrow amt0");
        run_op(pat[p], 6'd31, k[1:0], 1'b1, 0, "R1 R6 wide amt31");
        run_op(pat[p], 6'd32, k[1:0], 1'b1, 0, "R1 R6 wide amt32");
        run_op(pat[p], 6'd63, k[1:0], 1'b1, 0, "R6 wide amt63");
        run_op(pat[p], 6'd31, k[1:0], 1'b0, 0, "R6 narrow amt31");
        run_op(pat[p], 6'd33, k[1:0], 1'b0, 0, "R2 narrow amt bit5 ignored");
      end
    end
    run_op(64'hdead_beef_0000_0005, 6'd1, 2'b10, 1'b0, 0, "R1 code 2'b10 left");

    for (int i = 0; i < 600; i++) begin
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      run_op(d, 6'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), bit'($urandom_range(0, 2) == 0), "R2 R5 random");
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check("R10 gap no valid", {63'd0, out_valid}, 64'd0);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule